// File: doc/BRIEF.md
# TDM Frame Strobe Generator

This block derives the per-frame timing strobes of a 2048 kbit/s time-division backplane from a master clock (two master-clock cycles per bit period) and an active-low frame pulse. Each frame has 256 bit periods. The block produces three outputs: a bit clock at half the master-clock rate, an end-of-frame enable that is high for the last bit period of the frame, and a delayed active-low frame pulse placed a fixed number of bit periods after that enable.

The block also watches the incoming frame pulse. Nothing toggles until the first frame pulse has aligned the counters. A pulse held low stops the bit clock. When a frame goes by with no pulse, the enables stop while the bit clock keeps running. The next pulse brings everything back. An active-low power-down input clears all state at once and releases the output drivers. No data stream passes through this block, so it has no valid/ready handshake. Every pin is a plain level or strobe.

A frame pulse is a sampled 1-to-0 transition of `fp_n_i` on a rising master-clock edge. That edge is the alignment edge, and it sets the frame position to master cycle 0. Frames must last at least 512 master cycles. Longer frames are tolerated, because the position counter stops at its last value until the next pulse arrives.

Top module: `tdm_strobe_gen`

## Requirements
- R1: `out_en_o` follows `pwr_n_i` with no clock involved: it is 0 (outputs released) while `pwr_n_i` is 0 and 1 otherwise.
- R2: After power-down is released, `bclk_o` and `eof_o` stay 0 and `dfp_n_o` stays 1 until a frame pulse is sampled.
- R3: After an alignment edge, `bclk_o` is 1 for that master cycle, then toggles on every master-clock edge. Over a 512-cycle frame it is high for 256 cycles.
- R4: `eof_o` is 1 for exactly two master cycles, bit period 255, which is master cycles 510 and 511 counted from the alignment edge.
- R5: `dfp_n_o` is 0 for exactly two master cycles, in bit period 63 of the frame that follows an end-of-frame enable (64 bit periods after the enable rises). It does not appear in the first frame after alignment, and it is never low while `eof_o` is 1.
- R6: When `fp_n_i` is sampled low on three consecutive edges, `bclk_o` is held at 0 from the following cycle until the next frame pulse.
- R7: While `fp_n_i` stays high beyond the end of the frame, `bclk_o` keeps toggling and `eof_o` does not repeat.
- R8: The link is declared lost 1023 master cycles after the last alignment edge if no pulse is sampled on that edge. A pulse on that edge keeps the link, and the next frame carries `dfp_n_o`. A later pulse relocks the link, but the next frame carries no `dfp_n_o`. `bclk_o` keeps toggling throughout.
- R9: A frame longer than 512 cycles whose pulse arrives before the loss limit still gives exactly one end-of-frame enable, and the next frame carries the delayed pulse.
- R10: Power-down in the middle of a frame immediately forces `bclk_o`=0, `eof_o`=0 and `dfp_n_o`=1. After release, a new frame pulse is needed before anything toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock, two cycles per bit period |
| pwr_n_i | input | 1 | Active-low asynchronous power-down; also clears all state |
| fp_n_i | input | 1 | Incoming frame pulse, active low, synchronous to `mclk_i` |
| out_en_o | output | 1 | Output driver enable; 0 puts the strobe pads in high impedance |
| bclk_o | output | 1 | Bit clock, master clock divided by two |
| eof_o | output | 1 | End-of-frame enable, active high during bit period 255 |
| dfp_n_o | output | 1 | Delayed frame pulse, active low during bit period 63 |

## Verification
Two events can fall on the same master-clock edge: a frame pulse arriving, and the idle counter reaching the loss limit. The arriving pulse takes priority. The bench provokes this by ending a frame at a gap of exactly 1023 cycles and, separately, at 1024 cycles. It then judges which case kept the link by whether the following frame carries the delayed frame pulse. A stuck-low pulse also overlaps with the end-of-frame window: the frame position keeps counting while the bit clock is held low. This is judged by the bit-clock high count in that frame and in the frame after it.

// File: rtl/tdm_strobe_pkg.sv
package tdm_strobe_pkg;

  // Link supervision state shared by the timer and the strobe decoder.
  typedef enum logic [1:0] {
    LNK_IDLE = 2'd0,  // never aligned since power-up
    LNK_RUN  = 2'd1,  // aligned, pulses arriving in time
    LNK_LOST = 2'd2   // a frame went by without a pulse
  } lnk_e;

endpackage

// File: rtl/tsg_fp_monitor.sv
// Samples the frame pulse, reports the alignment edge and a stuck-low pulse.
module tsg_fp_monitor #(
  parameter int STUCK_LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic fp_n_i,
  output logic frame_start_o,
  output logic stuck_o
);
  localparam int CNT_W = $clog2(STUCK_LIMIT + 1);

  logic             fp_prev_q;
  logic [CNT_W-1:0] low_cnt_q;
  logic             stuck_q;

  assign frame_start_o = fp_prev_q & ~fp_n_i;
  assign stuck_o       = stuck_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fp_prev_q <= 1'b1;
      low_cnt_q <= '0;
      stuck_q   <= 1'b0;
    end else begin
      fp_prev_q <= fp_n_i;
      if (fp_n_i)
        low_cnt_q <= '0;
      else if (low_cnt_q != CNT_W'(STUCK_LIMIT))
        low_cnt_q <= low_cnt_q + 1'b1;
      // Stuck is declared on the sample after STUCK_LIMIT low samples;
      // only a fresh falling edge clears it.
      if (frame_start_o)
        stuck_q <= 1'b0;
      else if (!fp_n_i && low_cnt_q == CNT_W'(STUCK_LIMIT))
        stuck_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tsg_frame_timer.sv
// Master-cycle position inside the frame, bit-clock phase and loss supervision.
module tsg_frame_timer
  import tdm_strobe_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  parameter int SLACK_CYCLES   = 512
) (
  input  logic                                  clk_i,
  input  logic                                  rst_n_i,
  input  logic                                  frame_start_i,
  output logic [$clog2(BITS_PER_FRAME)-1:0]     bit_o,
  output logic                                  phase_o,
  output logic                                  overrun_o,
  output lnk_e                                  link_o
);
  localparam int MCLK_PER_FRAME = 2 * BITS_PER_FRAME;
  localparam int POS_W          = $clog2(MCLK_PER_FRAME);
  localparam int IDLE_W         = $clog2(SLACK_CYCLES + 1);

  logic [POS_W-1:0]  pos_q;
  logic [IDLE_W-1:0] idle_q;
  logic              phase_q;
  lnk_e              link_q;

  assign bit_o     = pos_q[POS_W-1:1];
  assign phase_o   = phase_q;
  assign overrun_o = (idle_q != '0);
  assign link_o    = link_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pos_q   <= '0;
      idle_q  <= '0;
      phase_q <= 1'b0;
      link_q  <= LNK_IDLE;
    end else if (frame_start_i) begin
      // A sampled pulse wins over the loss limit on the same edge.
      pos_q   <= '0;
      idle_q  <= '0;
      phase_q <= 1'b0;
      link_q  <= LNK_RUN;
    end else if (link_q != LNK_IDLE) begin
      phase_q <= ~phase_q;
      if (pos_q != POS_W'(MCLK_PER_FRAME - 1)) begin
        pos_q <= pos_q + 1'b1;
      end else if (idle_q != IDLE_W'(SLACK_CYCLES)) begin
        idle_q <= idle_q + 1'b1;
        if (idle_q == IDLE_W'(SLACK_CYCLES - 1))
          link_q <= LNK_LOST;
      end
    end
  end
endmodule

// File: rtl/tsg_strobe_out.sv
// Decodes the frame position into bit clock, end-of-frame and delayed pulse.
module tsg_strobe_out
  import tdm_strobe_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  parameter int DFP_DELAY      = 64   // legal range 1 .. BITS_PER_FRAME-1
) (
  input  logic                              clk_i,
  input  logic                              rst_n_i,
  input  lnk_e                              link_i,
  input  logic [$clog2(BITS_PER_FRAME)-1:0] bit_i,
  input  logic                              phase_i,
  input  logic                              overrun_i,
  input  logic                              stuck_i,
  output logic                              bclk_o,
  output logic                              eof_o,
  output logic                              dfp_n_o
);
  localparam int BIT_W   = $clog2(BITS_PER_FRAME);
  localparam int EOF_BIT = BITS_PER_FRAME - 1;
  localparam int DFP_BIT = DFP_DELAY - 1;

  logic armed_q;
  logic dfp_act;
  logic running;

  assign running = (link_i != LNK_IDLE);
  assign bclk_o  = running & ~stuck_i & ~phase_i;
  assign eof_o   = (link_i == LNK_RUN) & ~overrun_i & (bit_i == BIT_W'(EOF_BIT));
  assign dfp_act = (link_i == LNK_RUN) & ~overrun_i & armed_q &
                   (bit_i == BIT_W'(DFP_BIT));
  assign dfp_n_o = ~dfp_act;

  // Armed by an end-of-frame enable, spent by the delayed pulse.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)
      armed_q <= 1'b0;
    else if (link_i != LNK_RUN)
      armed_q <= 1'b0;
    else if (eof_o)
      armed_q <= 1'b1;
    else if (dfp_act && phase_i)
      armed_q <= 1'b0;
  end
endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
  import tdm_strobe_pkg::*;
#(
  parameter int BITS_PER_FRAME = 256,
  parameter int DFP_DELAY      = 64,
  parameter int STUCK_LIMIT    = 2,
  parameter int SLACK_CYCLES   = 512
) (
  input  logic mclk_i,
  input  logic pwr_n_i,
  input  logic fp_n_i,
  output logic out_en_o,
  output logic bclk_o,
  output logic eof_o,
  output logic dfp_n_o
);
  localparam int BIT_W = $clog2(BITS_PER_FRAME);

  logic             frame_start;
  logic             stuck;
  logic [BIT_W-1:0] bit_idx;
  logic             phase;
  logic             overrun;
  lnk_e             link;

  // Pad drivers are released straight from the power-down pin.
  assign out_en_o = pwr_n_i;

  tsg_fp_monitor #(
    .STUCK_LIMIT(STUCK_LIMIT)
  ) mon_i (
    .clk_i         (mclk_i),
    .rst_n_i       (pwr_n_i),
    .fp_n_i        (fp_n_i),
    .frame_start_o (frame_start),
    .stuck_o       (stuck)
  );

  tsg_frame_timer #(
    .BITS_PER_FRAME(BITS_PER_FRAME),
    .SLACK_CYCLES  (SLACK_CYCLES)
  ) tmr_i (
    .clk_i         (mclk_i),
    .rst_n_i       (pwr_n_i),
    .frame_start_i (frame_start),
    .bit_o         (bit_idx),
    .phase_o       (phase),
    .overrun_o     (overrun),
    .link_o        (link)
  );

  tsg_strobe_out #(
    .BITS_PER_FRAME(BITS_PER_FRAME),
    .DFP_DELAY     (DFP_DELAY)
  ) out_i (
    .clk_i     (mclk_i),
    .rst_n_i   (pwr_n_i),
    .link_i    (link),
    .bit_i     (bit_idx),
    .phase_i   (phase),
    .overrun_i (overrun),
    .stuck_i   (stuck),
    .bclk_o    (bclk_o),
    .eof_o     (eof_o),
    .dfp_n_o   (dfp_n_o)
  );
endmodule

// File: rtl/tdm_strobe_gen_chk.sv
module tdm_strobe_gen_chk (
  input logic mclk_i,
  input logic pwr_n_i,
  input logic fp_n_i,
  input logic bclk_o,
  input logic eof_o,
  input logic dfp_n_o
);
  logic fp_prev_q;
  logic seen_q;

  always_ff @(posedge mclk_i or negedge pwr_n_i) begin
    if (!pwr_n_i) begin
      fp_prev_q <= 1'b1;
      seen_q    <= 1'b0;
    end else begin
      fp_prev_q <= fp_n_i;
      seen_q    <= seen_q | (fp_prev_q & ~fp_n_i);
    end
  end

  a_r2_quiet_until_pulse: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    !seen_q |-> (!bclk_o && !eof_o && dfp_n_o));

  a_r3_bclk_high_after_pulse: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    (!fp_n_i && fp_prev_q) |=> bclk_o);

  a_r4_eof_lasts_two: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    $rose(eof_o) |=> eof_o);

  a_r4_eof_not_three: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    (eof_o && $past(eof_o)) |=> !eof_o);

  a_r5_dfp_lasts_two: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    $fell(dfp_n_o) |=> !dfp_n_o);

  a_r5_dfp_not_three: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    (!dfp_n_o && $past(!dfp_n_o)) |=> dfp_n_o);

  a_r5_no_overlap: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    !(eof_o && !dfp_n_o));

  a_r6_stuck_holds_bclk: assert property (@(posedge mclk_i) disable iff (!pwr_n_i)
    ($past(!fp_n_i) && $past(!fp_n_i, 2) && $past(!fp_n_i, 3)) |-> !bclk_o);
endmodule

bind tdm_strobe_gen tdm_strobe_gen_chk chk_i (
  .mclk_i  (mclk_i),
  .pwr_n_i (pwr_n_i),
  .fp_n_i  (fp_n_i),
  .bclk_o  (bclk_o),
  .eof_o   (eof_o),
  .dfp_n_o (dfp_n_o)
);

// File: tb/tdm_strobe_gen_tb_top.sv
module tdm_strobe_gen_tb_top;
  logic clk = 1'b0;
  logic pwr_n = 1'b0;
  logic fp_n = 1'b1;
  logic out_en, bclk, eof, dfp_n;
  int   n_chk = 0;
  int   n_err = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  tdm_strobe_gen dut_i (
    .mclk_i   (clk),
    .pwr_n_i  (pwr_n),
    .fp_n_i   (fp_n),
    .out_en_o (out_en),
    .bclk_o   (bclk),
    .eof_o    (eof),
    .dfp_n_o  (dfp_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  // Caller stands on a negedge. Pulse low for low_len edges; observe flen cycles.
  task automatic run_frame(input int low_len, input int flen,
                           output int eof_cnt, output int eof_first,
                           output int dfp_cnt, output int dfp_first,
                           output int bclk_hi);
    logic prev;
    eof_cnt = 0; eof_first = -1; dfp_cnt = 0; dfp_first = -1; bclk_hi = 0;
    prev = 1'b0;
    fp_n = 1'b0;
    for (int i = 1; i <= flen; i++) begin
      @(negedge clk);
      if (i == low_len) fp_n = 1'b1;
      if (eof) begin eof_cnt++; if (eof_first < 0) eof_first = i; end
      if (!dfp_n) begin dfp_cnt++; if (dfp_first < 0) dfp_first = i; end
      if (bclk) bclk_hi++;
      prev = bclk;
    end
  endtask

  task automatic quiet_window(input string req, input int len);
    int act = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (bclk || eof || !dfp_n) act++;
    end
    chk(req, act, 0);
  endtask

  task automatic t_reset();
    #3;
    chk("R1 out_en in power-down", out_en, 0);
    @(negedge clk);
    pwr_n = 1'b1;
    #1;
    chk("R1 out_en after release", out_en, 1);
    quiet_window("R2 quiet before first pulse", 700);
  endtask

  task automatic t_first_frames();
    int ec, ef, dc, df, bh;
    run_frame(2, 512, ec, ef, dc, df, bh);
    chk("R3 bclk high count", bh, 256);
    chk("R4 eof width first frame", ec, 2);
    chk("R4 eof position", ef, 511);
    chk("R5 no dfp in first frame", dc, 0);
    run_frame(2, 512, ec, ef, dc, df, bh);
    chk("R4 eof width steady", ec, 2);
    chk("R5 dfp width", dc, 2);
    chk("R5 dfp position", df, 127);
  endtask

  task automatic t_hold_high();
    int ec, ef, dc, df, bh;
    run_frame(2, 600, ec, ef, dc, df, bh);
    chk("R7 bclk keeps running", bh, 300);
    chk("R7 eof not repeated", ec, 2);
    chk("R9 eof position long frame", ef, 511);
    run_frame(2, 512, ec, ef, dc, df, bh);
    chk("R9 dfp after long frame", dc, 2);
    chk("R9 eof after long frame", ec, 2);
  endtask

  task automatic t_stuck();
    int ec, ef, dc, df, bh;
    run_frame(10, 512, ec, ef, dc, df, bh);
    chk("R6 bclk held low when stuck", bh, 1);
    run_frame(2, 512, ec, ef, dc, df, bh);
    chk("R6 bclk recovers", bh, 256);
  endtask

  task automatic t_loss_edge();
    int ec, ef, dc, df, bh;
    run_frame(2, 1023, ec, ef, dc, df, bh);
    chk("R8 eof before limit", ec, 2);
    run_frame(2, 512, ec, ef, dc, df, bh);
    chk("R8 pulse on limit keeps link", dc, 2);
    run_frame(2, 1024, ec, ef, dc, df, bh);
    chk("R8 bclk runs through loss", bh, 512);
    run_frame(2, 512, ec, ef, dc, df, bh);
    chk("R8 no dfp after loss", dc, 0);
    chk("R8 eof after relock", ec, 2);
  endtask

  task automatic t_pwrdn();
    int ec, ef, dc, df, bh;
    fp_n = 1'b0;
    for (int i = 1; i <= 50; i++) begin
      @(negedge clk);
      if (i == 2) fp_n = 1'b1;
    end
    #2;
    pwr_n = 1'b0;
    #1;
    chk("R1 out_en drops at once", out_en, 0);
    chk("R10 bclk forced low", bclk, 0);
    chk("R10 dfp_n forced high", dfp_n, 1);
    @(negedge clk);
    pwr_n = 1'b1;
    quiet_window("R10 quiet after release", 600);
    run_frame(2, 512, ec, ef, dc, df, bh);
    chk("R10 bclk after relock", bh, 256);
    chk("R10 eof after relock", ec, 2);
    chk("R10 no dfp first frame", dc, 0);
  endtask

  initial begin
    t_reset();
    t_first_frames();
    t_hold_high();
    t_stuck();
    t_loss_edge();
    t_pwrdn();
    finish_run();
  end
endmodule